// File: doc/BRIEF.md
# Priority Interrupt Controller with Two-Pulse Acknowledge

This block collects eight interrupt request lines, latches each rising edge into a request register, and raises one interrupt line toward the processor while a request is waiting that nothing of equal or higher rank is already serving. The processor answers with two acknowledge strobes. The first strobe picks the winning request, records it in the in-service register and drops it from the request register. The second strobe puts an 8-bit vector on the vector output. The vector is a programmable base with the 3-bit level in its low bits.

A small host port gives software two more ways in. A command write chooses whether reads of the command address return the raw request register or the in-service register. Another command arms a one-shot poll: the next read of the command address returns the winning level and acknowledges it, just as the first strobe would. This suits a processor that cannot produce acknowledge strobes. A further command ends the current interrupt by clearing the highest-ranked in-service bit. Input 0 has the highest rank and input 7 the lowest. A per-input mask keeps a line out of both the interrupt output and the arbitration.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the request, in-service, mask and base registers all read as zero, `int_o` is low, and command-address reads return the request register.
- R2: A low-to-high transition on `req_i[i]` sets request bit i one clock later. A line that stays high does not set its bit again after an acknowledge has cleared it.
- R3: `int_o` is high exactly when some unmasked request bit i is set and no in-service bit j with j <= i is set.
- R4: The first strobe of an acknowledge pair (`ack_i` high while the pair is idle) chooses the lowest-numbered eligible bit in the sense of R3. It sets that bit in the in-service register and clears it from the request register.
- R5: The second strobe of the pair makes `vec_valid_o` high during that cycle, with `vec_o` = {base[7:3], level}, where level is the one latched by the first strobe.
- R6: When the first strobe finds no eligible request, the latched level is 7 and the in-service register does not change.
- R7: Writing 0x0A to address 0 makes command-address reads return the request register. Writing 0x0B makes them return the in-service register. The choice holds until the next such write.
- R8: Writing 0x0C to address 0 arms a poll. The next read of address 0 returns {eligible-present flag in bit 7, 0000, level in bits [2:0]} and commits like a first strobe (R4, R6). Later reads return to the R7 selection.
- R9: Writing 0x20 to address 0 clears the lowest-numbered set in-service bit and leaves the others unchanged.
- R10: A set mask bit keeps that request out of `int_o` and out of the arbitration, while the raw request bit still sets and still reads back.
- R11: Address 1 writes and reads the mask register. Address 2 writes and reads the base register. Address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Interrupt request lines, captured on their rising edges |
| ack_i | input | 1 | Acknowledge strobe; two strobes form one acknowledge |
| wr_i | input | 1 | Host write strobe |
| rd_i | input | 1 | Host read strobe; a read of address 0 during an armed poll commits it |
| addr_i | input | 2 | Host address: 0 command/status, 1 mask, 2 base |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data; valid while rd_i is high |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Interrupt vector |
| vec_valid_o | output | 1 | High during the second acknowledge strobe |

## Verification
The hardest state to reach is a nested one: a lower-ranked interrupt in service, a higher-ranked request arriving on top of it, and several requests pending but blocked. The case matters because R3 and R9 must then tell apart bits that only differ by rank. The bench reaches it in two ways. It drives all 255 non-empty request patterns and drains each through acknowledge and end-of-interrupt pairs, so that every step leaves the remaining requests blocked behind the bit just served. A directed sequence then lets a high-ranked edge preempt a line already in service. A second sweep covers all 256 masks against a full request word, using the poll path.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam logic [7:0] CMD_SEL_REQ = 8'h0A;
  localparam logic [7:0] CMD_SEL_SVC = 8'h0B;
  localparam logic [7:0] CMD_POLL    = 8'h0C;
  localparam logic [7:0] CMD_EOI     = 8'h20;

  localparam logic [1:0] ADDR_CMD  = 2'd0;
  localparam logic [1:0] ADDR_MASK = 2'd1;
  localparam logic [1:0] ADDR_BASE = 2'd2;

  typedef enum logic {
    RSEL_REQ = 1'b0,
    RSEL_SVC = 1'b1
  } rsel_e;
endpackage

// File: rtl/prio_irq_cap.sv
module prio_irq_cap #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] irr_o
);
  logic [N-1:0] req_q;
  logic [N-1:0] rise;

  assign rise = req_i & ~req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= '0;
      irr_o <= '0;
    end else begin
      req_q <= req_i;
      irr_o <= (irr_o & ~clr_i) | rise;
    end
  end
endmodule

// File: rtl/prio_irq_pick.sv
// lowest-numbered set bit wins
module prio_irq_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0] vec_i,
  output logic [N-1:0] oh_o,
  output logic         valid_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      oh_o[i] = vec_i[i] & ~found;
      found   = found | vec_i[i];
    end
    valid_o = found;
  end
endmodule

// File: rtl/prio_irq_enc.sv
module prio_irq_enc #(
  parameter int N  = 8,
  localparam int LW = $clog2(N)
) (
  input  logic [N-1:0]  oh_i,
  output logic [LW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (oh_i[i]) idx_o = idx_o | LW'(i);
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int N = 8,
  localparam int LW = $clog2(N)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic         ack_i,
  input  logic         wr_i,
  input  logic         rd_i,
  input  logic [1:0]   addr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] rdata_o,
  output logic         int_o,
  output logic [N-1:0] vec_o,
  output logic         vec_valid_o
);
  logic [N-1:0]  irr_q, isr_q, mask_q, base_q;
  logic [N-1:0]  blk, elig, win_oh, svc_oh, set_oh, eoi_clr;
  logic          win_vld, svc_vld;
  logic [LW-1:0] win_idx, lvl, lvl_q;
  logic          ack_ph_q, poll_q;
  rsel_e         rsel_q;
  logic          cmd_wr, eoi_wr, poll_rd, ack_first, commit;

  prio_irq_cap #(.N(N)) u_cap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (req_i),
    .clr_i (set_oh),
    .irr_o (irr_q)
  );

  // bit i is blocked if any in-service bit at rank i or above is set
  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < N; i++) begin
      acc    = acc | isr_q[i];
      blk[i] = acc;
    end
  end

  assign elig  = irr_q & ~mask_q & ~blk;
  assign int_o = |elig;

  prio_irq_pick #(.N(N)) u_win (
    .vec_i  (elig),
    .oh_o   (win_oh),
    .valid_o(win_vld)
  );

  prio_irq_enc #(.N(N)) u_enc (
    .oh_i (win_oh),
    .idx_o(win_idx)
  );

  prio_irq_pick #(.N(N)) u_svc (
    .vec_i  (isr_q),
    .oh_o   (svc_oh),
    .valid_o(svc_vld)
  );

  assign cmd_wr    = wr_i && (addr_i == ADDR_CMD);
  assign eoi_wr    = cmd_wr && (wdata_i == CMD_EOI);
  assign poll_rd   = rd_i && (addr_i == ADDR_CMD) && poll_q;
  assign ack_first = ack_i && !ack_ph_q;
  assign commit    = ack_first || poll_rd;
  assign set_oh    = commit ? win_oh : '0;
  assign eoi_clr   = (eoi_wr && svc_vld) ? svc_oh : '0;
  assign lvl       = win_vld ? win_idx : LW'(N - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q    <= '0;
      mask_q   <= '0;
      base_q   <= '0;
      lvl_q    <= '0;
      ack_ph_q <= 1'b0;
      poll_q   <= 1'b0;
      rsel_q   <= RSEL_REQ;
    end else begin
      isr_q <= (isr_q & ~eoi_clr) | set_oh;
      if (ack_i) ack_ph_q <= ~ack_ph_q;
      if (ack_first) lvl_q <= lvl;
      if (poll_rd) poll_q <= 1'b0;
      if (wr_i) begin
        unique case (addr_i)
          ADDR_MASK: mask_q <= wdata_i;
          ADDR_BASE: base_q <= wdata_i;
          ADDR_CMD: begin
            if (wdata_i == CMD_SEL_REQ) rsel_q <= RSEL_REQ;
            if (wdata_i == CMD_SEL_SVC) rsel_q <= RSEL_SVC;
            if (wdata_i == CMD_POLL)    poll_q <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign vec_o       = {base_q[N-1:LW], lvl_q};
  assign vec_valid_o = ack_i && ack_ph_q;

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        ADDR_CMD: begin
          if (poll_q)                  rdata_o = {win_vld, {(N-1-LW){1'b0}}, lvl};
          else if (rsel_q == RSEL_SVC) rdata_o = isr_q;
          else                         rdata_o = irr_q;
        end
        ADDR_MASK: rdata_o = mask_q;
        ADDR_BASE: rdata_o = base_q;
        default:   rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int N = 8,
  localparam int LW = $clog2(N)
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         ack_i,
  input logic         wr_i,
  input logic         int_o,
  input logic         vec_valid_o,
  input logic [N-1:0] vec_o,
  input logic [N-1:0] base_q,
  input logic [N-1:0] irr_q,
  input logic [N-1:0] isr_q,
  input logic [N-1:0] mask_q,
  input logic         poll_q,
  input logic         ack_ph_q,
  input logic         eoi_wr,
  input logic         poll_rd,
  input logic         commit
);
  p_int_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> ((irr_q & ~mask_q) != '0));

  p_commit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !ack_ph_q && int_o && !eoi_wr)
      |=> ($countones(isr_q) == $past($countones(isr_q)) + 1));

  p_vec_base_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> (vec_o[N-1:LW] == base_q[N-1:LW]));

  p_pair_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && ack_ph_q) |=> !ack_ph_q);

  p_spurious_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !ack_ph_q && !int_o && !eoi_wr) |=> (isr_q == $past(isr_q)));

  p_poll_once_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poll_rd && !wr_i) |=> !poll_q);

  p_eoi_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_wr && !commit && (isr_q != '0))
      |=> ($countones(isr_q) + 1 == $past($countones(isr_q))));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N(N)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ack_i      (ack_i),
  .wr_i       (wr_i),
  .int_o      (int_o),
  .vec_valid_o(vec_valid_o),
  .vec_o      (vec_o),
  .base_q     (base_q),
  .irr_q      (irr_q),
  .isr_q      (isr_q),
  .mask_q     (mask_q),
  .poll_q     (poll_q),
  .ack_ph_q   (ack_ph_q),
  .eoi_wr     (eoi_wr),
  .poll_rd    (poll_rd),
  .commit     (commit)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] req_i = '0;
  logic         ack_i = 1'b0;
  logic         wr_i = 1'b0;
  logic         rd_i = 1'b0;
  logic [1:0]   addr_i = '0;
  logic [N-1:0] wdata_i = '0;
  logic [N-1:0] rdata_o;
  logic         int_o;
  logic [N-1:0] vec_o;
  logic         vec_valid_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  prio_irq_ctrl #(.N(N)) u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .ack_i      (ack_i),
    .wr_i       (wr_i),
    .rd_i       (rd_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .int_o      (int_o),
    .vec_o      (vec_o),
    .vec_valid_o(vec_valid_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic int lowest(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 7;
  endfunction

  // all tasks start and end at a falling edge
  task automatic do_reset();
    rst_ni = 1'b0; req_i = '0; ack_i = 0; wr_i = 0; rd_i = 0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr_i = a; rd_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic ack_pair(output logic [7:0] v, output logic vv);
    ack_i = 1'b1;
    @(negedge clk_i);
    ack_i = 1'b0;
    @(negedge clk_i);
    ack_i = 1'b1;
    #1 v = vec_o; vv = vec_valid_o;
    @(negedge clk_i);
    ack_i = 1'b0;
  endtask

  task automatic set_req(input logic [7:0] p);
    req_i = p;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d, v, base, rem, m, isr;
    logic vv;
    int l;

    // R1 reset state
    @(negedge clk_i);
    do_reset();
    chk("R1 int", {7'b0, int_o}, 8'h00);
    rd(2'd0, d); chk("R1 irr", d, 8'h00);
    rd(2'd1, d); chk("R1 mask", d, 8'h00);
    rd(2'd2, d); chk("R1 base", d, 8'h00);
    wr(2'd0, 8'h0B); rd(2'd0, d); chk("R1 isr", d, 8'h00);

    // R11 register access
    wr(2'd1, 8'h5A); rd(2'd1, d); chk("R11 mask", d, 8'h5A);
    wr(2'd2, 8'hC3); rd(2'd2, d); chk("R11 base", d, 8'hC3);
    rd(2'd3, d); chk("R11 addr3", d, 8'h00);

    // nested preemption: R3, R4, R9
    do_reset();
    wr(2'd2, 8'h40);
    set_req(8'h20);
    chk("R3 single", {7'b0, int_o}, 8'h01);
    ack_pair(v, vv);
    chk("R5 valid", {7'b0, vv}, 8'h01);
    chk("R5 vec5", v, 8'h45);
    chk("R3 served", {7'b0, int_o}, 8'h00);
    set_req(8'h24);
    chk("R3 preempt", {7'b0, int_o}, 8'h01);
    ack_pair(v, vv);
    chk("R4 vec2", v, 8'h42);
    wr(2'd0, 8'h0B); rd(2'd0, d); chk("R4 isr nested", d, 8'h24);
    wr(2'd0, 8'h20); rd(2'd0, d); chk("R9 eoi lowest", d, 8'h20);
    wr(2'd0, 8'h20); rd(2'd0, d); chk("R9 eoi last", d, 8'h00);
    wr(2'd0, 8'h0A); rd(2'd0, d); chk("R2 held no reset", d, 8'h00);
    chk("R7 sel persists", d, 8'h00);

    // R10 mask and R6 spurious
    do_reset();
    wr(2'd1, 8'h08);
    set_req(8'h08);
    chk("R10 masked int", {7'b0, int_o}, 8'h00);
    rd(2'd0, d); chk("R10 raw irr", d, 8'h08);
    ack_pair(v, vv);
    chk("R6 spurious vec", v, 8'h07);
    wr(2'd0, 8'h0B); rd(2'd0, d); chk("R6 isr unchanged", d, 8'h00);
    wr(2'd1, 8'h00);
    chk("R10 unmask int", {7'b0, int_o}, 8'h01);

    // sweep every request pattern through ack/EOI pairs
    for (int p = 1; p < 256; p++) begin
      do_reset();
      base = 8'(p << 3) ^ 8'hA5;
      wr(2'd2, base);
      set_req(8'(p));
      rd(2'd0, d); chk("R2 capture", d, 8'(p));
      rem = 8'(p);
      while (rem != 0) begin
        chk("R3 pending", {7'b0, int_o}, 8'h01);
        l = lowest(rem);
        ack_pair(v, vv);
        chk("R5 vec", v, {base[7:3], 3'(l)});
        rem[l] = 1'b0;
        chk("R3 blocked", {7'b0, int_o}, 8'h00);
        wr(2'd0, 8'h0B); rd(2'd0, d); chk("R4 isr", d, 8'(1 << l));
        wr(2'd0, 8'h0A); rd(2'd0, d); chk("R4 irr", d, rem);
        wr(2'd0, 8'h20);
        chk("R9 after eoi", {7'b0, int_o}, {7'b0, rem != 0});
      end
      ack_pair(v, vv);
      chk("R6 drained vec", v, {base[7:3], 3'd7});
      wr(2'd0, 8'h0B); rd(2'd0, d); chk("R6 drained isr", d, 8'h00);
    end

    // sweep every mask through the poll path
    for (int k = 0; k < 256; k++) begin
      do_reset();
      m = 8'(k);
      wr(2'd1, m);
      set_req(8'hFF);
      chk("R10 int", {7'b0, int_o}, {7'b0, m != 8'hFF});
      l = lowest(~m);
      wr(2'd0, 8'h0C);
      rd(2'd0, d);
      chk("R8 poll", d, {m != 8'hFF, 4'b0, 3'(l)});
      rd(2'd0, d);
      chk("R8 one shot irr", d, (m == 8'hFF) ? 8'hFF : (8'hFF & ~8'(1 << l)));
      wr(2'd0, 8'h0B); rd(2'd0, d);
      isr = (m == 8'hFF) ? 8'h00 : 8'(1 << l);
      chk("R8 poll isr", d, isr);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule